// File: doc/BRIEF.md
# Per-Group Delay Step Command Register

This block holds four recombiner delay values, one for each group, and the command bits that software uses to move them. Each group has a raise bit and a lower bit. Software writes a 1 to a bit to ask for one step of adjustment. The size of that step comes from a separate per-group step register, which this block receives as an input bus.

A request does not take effect when it is written. It stays pending until the next pulse on the update-strobe input. On that pulse each group with a pending request applies at most one step, and the bits it consumed clear. Software can therefore poll a bit: once it reads back 0, the delay has actually changed.

The delay values never wrap around. They stop at zero and at their all-ones maximum. All four values are presented on a parallel output bus.

Top module: `dly_step_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all command bits read 0 and all four delay values read 0.
- R2: A write sets each command bit whose written data bit is 1. For group g, bit 2g is the raise (increment) bit and bit 2g+1 is the lower (decrement) bit.
- R3: A written 0 leaves its command bit unchanged. A pending bit stays at 1, and every delay value stays unchanged, for as long as no update strobe occurs.
- R4: On an update strobe, a group whose only pending request is a raise adds its step value to its delay, and its raise bit clears.
- R5: On an update strobe, a group whose only pending request is a lower subtracts its step value from its delay, and its lower bit clears.
- R6: On an update strobe, a group with both a raise and a lower pending clears both bits and keeps its delay unchanged.
- R7: A raise that would pass the maximum value (2^DLY_W-1, which is 255 by default) leaves the delay at that maximum.
- R8: A lower step larger than the current delay leaves the delay at 0.
- R9: A bit written in the same cycle as an update strobe is not consumed by that strobe. It stays pending for the following strobe.
- R10: The groups are independent. A group with no pending request keeps its delay through a strobe, and no group moves by more than one step per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the command register |
| wr_data | input | 2*NUM_GRP | Write data; a 1 requests the matching adjustment |
| step_val | input | NUM_GRP*STEP_W | Step size for each group; group g uses bits [g*STEP_W +: STEP_W] |
| upd_stb | input | 1 | Update strobe; pending requests are applied on the edge where it is high |
| cmd_rd | output | 2*NUM_GRP | Read-back of the pending command bits |
| dly_out | output | NUM_GRP*DLY_W | Delay values; group g is at bits [g*DLY_W +: DLY_W] |

## Verification
The assertions check the following on every cycle:
- A written 1 always appears in the read-back.
- Command bits and delays never change without a strobe.
- Every bit that was pending when a strobe arrived is gone afterwards, unless it was rewritten in the same cycle.
- A strobe moves each group only in the direction its pending bits allow.

The exact arithmetic can only be shown by the bench scenarios, because it depends on the delay held before the strobe:
- the step sums and differences;
- saturation at 255 and at 0;
- the deferral of a bit written in the same cycle as a strobe;
- the return to zero on reset.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;

  // Decoded per-group request, built from the raise bit and the lower bit.
  typedef enum logic [1:0] {
    ADJ_NONE = 2'b00,
    ADJ_UP   = 2'b01,
    ADJ_DN   = 2'b10,
    ADJ_BOTH = 2'b11
  } adj_op_e;

endpackage

// File: rtl/dly_rst_sync.sv
module dly_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dly_cmd_bits.sv
module dly_cmd_bits #(
  parameter int NUM_GRP = 4,
  localparam int CW = 2 * NUM_GRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          upd_stb,
  output logic [CW-1:0] cmd_q
);
  logic [CW-1:0] set_mask;
  logic [CW-1:0] clr_mask;
  logic [CW-1:0] cmd_d;
  logic          cmd_en;

  always_comb begin
    // Only written ones set bits; a written zero does nothing.
    set_mask = wr_en ? wr_data : '0;
    // A strobe consumes whatever was pending before this cycle.
    clr_mask = upd_stb ? cmd_q : '0;
    // A set in the same cycle wins, so that request waits for the next strobe.
    cmd_d    = (cmd_q & ~clr_mask) | set_mask;
    cmd_en   = wr_en | upd_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end
endmodule

// File: rtl/dly_acc.sv
module dly_acc
  import dly_step_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int STEP_W = 8,
  localparam int SUM_W = ((DLY_W > STEP_W) ? DLY_W : STEP_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  input  adj_op_e           op,
  input  logic [STEP_W-1:0] step,
  output logic [DLY_W-1:0]  dly_q
);
  localparam logic [SUM_W-1:0] MAX_W = SUM_W'((1 << DLY_W) - 1);

  logic [SUM_W-1:0] cur_w;
  logic [SUM_W-1:0] step_w;
  logic [SUM_W-1:0] sum_w;
  logic [DLY_W-1:0] dly_d;
  logic             dly_en;

  always_comb begin
    cur_w  = SUM_W'(dly_q);
    step_w = SUM_W'(step);
    sum_w  = cur_w + step_w;
    dly_d  = dly_q;
    unique case (op)
      // Raise, clamped at the all-ones maximum.
      ADJ_UP:  dly_d = (sum_w > MAX_W) ? MAX_W[DLY_W-1:0] : sum_w[DLY_W-1:0];
      // Lower, clamped at zero.
      ADJ_DN:  dly_d = (step_w > cur_w) ? '0 : DLY_W'(cur_w - step_w);
      // Raise and lower together cancel; no request keeps the value.
      default: dly_d = dly_q;
    endcase
    dly_en = upd_stb && (op == ADJ_UP || op == ADJ_DN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (dly_en) dly_q <= dly_d;
  end
endmodule

// File: rtl/dly_step_ctrl.sv
module dly_step_ctrl
  import dly_step_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int DLY_W   = 8,
  parameter int STEP_W  = 8,
  localparam int CW = 2 * NUM_GRP
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CW-1:0]             wr_data,
  input  logic [NUM_GRP*STEP_W-1:0] step_val,
  input  logic                      upd_stb,
  output logic [CW-1:0]             cmd_rd,
  output logic [NUM_GRP*DLY_W-1:0]  dly_out
);
  logic          rst_q;
  logic [CW-1:0] cmd_q;

  dly_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  dly_cmd_bits #(.NUM_GRP(NUM_GRP)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .upd_stb (upd_stb),
    .cmd_q   (cmd_q)
  );

  assign cmd_rd = cmd_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    adj_op_e op;
    // Bit 2g+1 is the lower request and bit 2g is the raise request.
    assign op = adj_op_e'({cmd_q[2*g+1], cmd_q[2*g]});

    dly_acc #(.DLY_W(DLY_W), .STEP_W(STEP_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_q),
      .upd_stb (upd_stb),
      .op      (op),
      .step    (step_val[g*STEP_W +: STEP_W]),
      .dly_q   (dly_out[g*DLY_W +: DLY_W])
    );
  end
endmodule

// File: rtl/dly_step_chk.sv
module dly_step_chk #(
  parameter int NUM_GRP = 4,
  parameter int DLY_W   = 8,
  localparam int CW = 2 * NUM_GRP
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [CW-1:0]            wr_data,
  input logic                     upd_stb,
  input logic [CW-1:0]            cmd_rd,
  input logic [NUM_GRP*DLY_W-1:0] dly_out
);
  logic [CW-1:0] wr_mask;
  assign wr_mask = wr_en ? wr_data : '0;

  AST_SET_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cmd_rd & $past(wr_data)) == $past(wr_data)));                  // R2
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> ((cmd_rd & $past(cmd_rd)) == $past(cmd_rd)));                 // R3
  AST_DLY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> $stable(dly_out));                                            // R3
  AST_CLR_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> ((cmd_rd & $past(cmd_rd) & ~$past(wr_mask)) == '0));           // R9

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && cmd_rd[2*g] && !cmd_rd[2*g+1])
      |=> (dly_out[g*DLY_W +: DLY_W] >= $past(dly_out[g*DLY_W +: DLY_W])));  // R7
    AST_DN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !cmd_rd[2*g] && cmd_rd[2*g+1])
      |=> (dly_out[g*DLY_W +: DLY_W] <= $past(dly_out[g*DLY_W +: DLY_W])));  // R8
    AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && cmd_rd[2*g] && cmd_rd[2*g+1])
      |=> $stable(dly_out[g*DLY_W +: DLY_W]));                                 // R6
    AST_IDLE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !cmd_rd[2*g] && !cmd_rd[2*g+1])
      |=> $stable(dly_out[g*DLY_W +: DLY_W]));                                 // R10
  end
endmodule

bind dly_step_ctrl dly_step_chk #(.NUM_GRP(NUM_GRP), .DLY_W(DLY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .upd_stb (upd_stb),
  .cmd_rd  (cmd_rd),
  .dly_out (dly_out)
);

// File: tb/sim_dly_step_ctrl.sv
module sim_dly_step_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  // Each vector: write enable, write data, strobe, step for all groups,
  // expected command read-back, expected delays {g3,g2,g1,g0}.
  typedef struct packed {
    logic        we;
    logic [7:0]  wd;
    logic        stb;
    logic [7:0]  step;
    logic [7:0]  exp_cmd;
    logic [31:0] exp_dly;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h01, 1'b0, 8'd5,   8'h01, 32'h0000_0000}, // R2: group 0 raise pending
    '{1'b1, 8'h00, 1'b0, 8'd5,   8'h01, 32'h0000_0000}, // R3: writing zero has no effect
    '{1'b0, 8'h00, 1'b1, 8'd5,   8'h00, 32'h0000_0005}, // R4: +5
    '{1'b1, 8'h0A, 1'b1, 8'd3,   8'h00, 32'h0000_0002}, // R5 g0 -3, R8 g1 stays 0
    '{1'b1, 8'h30, 1'b1, 8'd7,   8'h00, 32'h0000_0002}, // R6: both bits cancel
    '{1'b1, 8'h44, 1'b1, 8'd200, 8'h00, 32'hC800_C802}, // R10: g1 and g3 only
    '{1'b1, 8'h44, 1'b1, 8'd100, 8'h00, 32'hFF00_FF02}, // R7: clamp at 255
    '{1'b1, 8'h80, 1'b0, 8'd55,  8'h80, 32'hFF00_FF02}, // R3: pending, no strobe
    '{1'b0, 8'h00, 1'b1, 8'd55,  8'h00, 32'hC800_FF02}  // R5: g3 -55
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [31:0] step_val;
  logic        upd_stb;
  logic [7:0]  cmd_rd;
  logic [31:0] dly_out;
  int n_chk;
  int n_err;
  logic done;

  dly_step_ctrl u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .step_val (step_val),
    .upd_stb  (upd_stb),
    .cmd_rd   (cmd_rd),
    .dly_out  (dly_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] ec, input logic [31:0] ed);
    n_chk++;
    if (cmd_rd !== ec || dly_out !== ed) begin
      n_err++;
      $display("FAIL %s: cmd=%h dly=%h, expected cmd=%h dly=%h", req, cmd_rd, dly_out, ec, ed);
    end
  endtask

  // Inputs change on the falling edge; the rising edge in between captures them.
  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    upd_stb = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    done = 1'b0;
    step_val = '0;
    do_reset();
    check("R1 reset state", 8'h00, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step_val = {4{VECS[i].step}};
      if (VECS[i].we) begin
        wr_en = 1'b1;
        wr_data = VECS[i].wd;
        cyc();
        wr_en = 1'b0;
        wr_data = '0;
      end
      if (VECS[i].stb) begin
        upd_stb = 1'b1;
        cyc();
        upd_stb = 1'b0;
      end
      check($sformatf("vector %0d (R2..R10)", i), VECS[i].exp_cmd, VECS[i].exp_dly);
    end

    // R3: a pending bit survives many cycles without a strobe.
    wr_en = 1'b1;
    wr_data = 8'h01;
    cyc();
    wr_en = 1'b0;
    repeat (10) cyc();
    check("R3 long hold", 8'h01, 32'hC800_FF02);

    // R9: a write in the strobe cycle is deferred; the old raise is applied.
    step_val = {4{8'd1}};
    wr_en = 1'b1;
    wr_data = 8'h02;
    upd_stb = 1'b1;
    cyc();
    wr_en = 1'b0;
    upd_stb = 1'b0;
    check("R9 same-cycle write deferred", 8'h02, 32'hC800_FF03);
    upd_stb = 1'b1;
    cyc();
    upd_stb = 1'b0;
    check("R9 deferred lower applied", 8'h00, 32'hC800_FF02);

    // R1: reset in the middle of operation clears everything.
    wr_en = 1'b1;
    wr_data = 8'hFF;
    cyc();
    wr_en = 1'b0;
    rst_n = 1'b0;
    cyc();
    check("R1 reset during run", 8'h00, 32'h0);
    rst_n = 1'b1;
    repeat (4) cyc();
    check("R1 after re-release", 8'h00, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule